// File: doc/BRIEF.md
# Three-Mode Lookup Table Slice Cell

This cell holds sixteen storage bits that can be used in three ways. As a truth table, the four select inputs pick one bit and the cell computes any function of four inputs. As a small memory, those same bits form a 16x1 RAM. The RAM is written on the clock edge and read without waiting for a clock. As a serial delay line, the bits form a 16-bit shift register, and the select inputs choose which stage drives the output. That gives a delay that can be set from 1 to 16 cycles.

A truth table is loaded by writing it in memory mode and then switching to logic mode. A mode change leaves the stored bits as they are. The cell's output can come straight from the selection tree or from a flip-flop placed after it. A static configuration input picks which of the two is used.

Top module: `lut_slice_cell`

## Requirements
- R1: While `rst_n` is low at a rising edge, all sixteen stored bits and the output flip-flop are cleared, so that `lut_out` and `shift_out` read 0 afterwards.
- R2: In logic mode (`mode` = 2'b00), with `reg_sel` = 0, `lut_out` equals stored bit number `sel`, where `sel[0]` is the least significant index bit. The stored bits do not change, whatever `wr_en`, `wr_data` and `shift_in` are.
- R3: In memory mode (`mode` = 2'b01), `wr_en` = 1 at a rising edge stores `wr_data` into bit number `sel`. With `reg_sel` = 0, `lut_out` shows bit `sel` combinationally, in the same cycle.
- R4: In memory mode with `wr_en` = 0, no stored bit changes.
- R5: In shift mode (`mode` = 2'b10), `wr_en` = 1 at a rising edge moves each bit k up to bit k+1 and loads `shift_in` into bit 0. `shift_out` always shows bit 15.
- R6: In shift mode, `lut_out` (with `reg_sel` = 0) shows stage `sel`. A value shifted in appears there after `sel`+1 enabled edges.
- R7: In shift mode with `wr_en` = 0, no stored bit changes.
- R8: With `reg_sel` = 1, `lut_out` equals the value the selection tree gave just before the previous rising edge. In memory mode this is the bit value before any write at that edge.
- R9: A change of `mode` never alters the stored bits. The spare encoding 2'b11 behaves as logic mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mode | input | 2 | 00 logic, 01 memory, 10 shift, 11 treated as logic |
| reg_sel | input | 1 | 1 = registered output, 0 = direct output |
| sel | input | 4 | Table index / memory address / shift tap |
| wr_data | input | 1 | Data written in memory mode |
| wr_en | input | 1 | Write enable (memory) or shift enable (shift) |
| shift_in | input | 1 | Serial data entering stage 0 |
| lut_out | output | 1 | Selected bit, direct or registered |
| shift_out | output | 1 | Last shift stage (bit 15) |

## Verification
The direct output and `shift_out` depend only on the inputs and the stored bits, so they are due in the same cycle. The bench drives inputs on the falling edge and compares 1 ns later, before the next rising edge. A write or a shift takes effect at the next rising edge, and the registered output is due one edge after the value it copies. The bench's reference model advances its stored bits and its flip-flop copy only once per step, after that step's comparison, which matches one register stage. Rules that say "no change" are confirmed by reading all sixteen bits back in logic mode immediately after the stimulus.

// File: rtl/lut_slice_pkg.sv
// Shared definitions for the lookup table slice cell.
// Assumes: mode encoding is fixed by the top-level port contract.
package lut_slice_pkg;
    typedef enum logic [1:0] {
        LM_LOGIC = 2'b00,
        LM_RAM   = 2'b01,
        LM_SHIFT = 2'b10,
        LM_SPARE = 2'b11
    } lut_mode_e;
endpackage

// File: rtl/lut_cfg_store.sv
// Sixteen (2**SEL_W) storage bits shared by all three modes.
// Memory mode writes one addressed bit, shift mode shifts towards the MSB,
// and logic/spare modes hold. Assumes a synchronous active-low reset.
module lut_cfg_store
    import lut_slice_pkg::*;
#(
    parameter int SEL_W = 4,
    localparam int DEPTH = 1 << SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  lut_mode_e        mode,
    input  logic [SEL_W-1:0] sel,
    input  logic             wr_data,
    input  logic             wr_en,
    input  logic             shift_in,
    output logic [DEPTH-1:0] bits_q
);
    // Update the storage according to the mode; other modes leave it alone.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else if (wr_en) begin
            case (mode)
                LM_RAM:   bits_q[sel] <= wr_data;
                LM_SHIFT: bits_q <= {bits_q[DEPTH-2:0], shift_in};
                default:  bits_q <= bits_q;
            endcase
        end
    end
endmodule

// File: rtl/lut_mux_tree.sv
// Binary selection tree laid out as a heap of 2*DEPTH-1 nodes.
// Leaves hold the storage bits; the root is steered by the select MSB.
// Assumes purely combinational use.
module lut_mux_tree #(
    parameter int SEL_W = 4,
    localparam int DEPTH = 1 << SEL_W,
    localparam int NODES = 2 * DEPTH - 1
) (
    input  logic [DEPTH-1:0] leaves,
    input  logic [SEL_W-1:0] sel,
    output logic             tap
);
    logic [NODES-1:0] node;

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_leaf
            assign node[DEPTH-1+gi] = leaves[gi];
        end
        for (gi = 0; gi < DEPTH - 1; gi++) begin : g_inner
            localparam int LVL = $clog2(gi + 2) - 1;
            assign node[gi] = sel[SEL_W-1-LVL] ? node[2*gi+2] : node[2*gi+1];
        end
    endgenerate

    assign tap = node[0];
endmodule

// File: rtl/lut_out_stage.sv
// Optional output flip-flop after the selection tree.
// The flip-flop samples on every edge; reg_sel only chooses which value leaves.
// Assumes reg_sel is a static configuration input.
module lut_out_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic reg_sel,
    input  logic tap,
    output logic lut_out
);
    logic tap_q;

    // Capture the tree output each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) tap_q <= 1'b0;
        else        tap_q <= tap;
    end

    // Pick the registered or direct path.
    always_comb lut_out = reg_sel ? tap_q : tap;
endmodule

// File: rtl/lut_slice_cell.sv
// Top of the three-mode lookup table slice: storage, selection tree and
// output stage. Assumes synchronous active-low reset and static reg_sel.
module lut_slice_cell
    import lut_slice_pkg::*;
#(
    parameter int SEL_W = 4,
    localparam int DEPTH = 1 << SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic             reg_sel,
    input  logic [SEL_W-1:0] sel,
    input  logic             wr_data,
    input  logic             wr_en,
    input  logic             shift_in,
    output logic             lut_out,
    output logic             shift_out
);
    lut_mode_e        mode_e;
    logic [DEPTH-1:0] mem_bits;
    logic             tap_bit;

    // Decode the raw mode pins into the shared enum.
    always_comb mode_e = lut_mode_e'(mode);

    lut_cfg_store #(.SEL_W(SEL_W)) u_store (
        .clk(clk), .rst_n(rst_n), .mode(mode_e), .sel(sel),
        .wr_data(wr_data), .wr_en(wr_en), .shift_in(shift_in),
        .bits_q(mem_bits)
    );

    lut_mux_tree #(.SEL_W(SEL_W)) u_tree (
        .leaves(mem_bits), .sel(sel), .tap(tap_bit)
    );

    lut_out_stage u_out (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel),
        .tap(tap_bit), .lut_out(lut_out)
    );

    assign shift_out = mem_bits[DEPTH-1];
endmodule

// File: rtl/lut_slice_chk.sv
// Property checker for the slice cell, attached by bind below.
// Assumes store and tap are the top's storage vector and tree output.
module lut_slice_chk
    import lut_slice_pkg::*;
#(
    parameter int SEL_W = 4,
    localparam int DEPTH = 1 << SEL_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode,
    input logic             reg_sel,
    input logic [SEL_W-1:0] sel,
    input logic             wr_data,
    input logic             wr_en,
    input logic             shift_in,
    input logic             lut_out,
    input logic [DEPTH-1:0] store,
    input logic             tap
);
    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (store == '0)); // R1
    AST_LOGIC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LM_LOGIC || mode == LM_SPARE) |=> $stable(store)); // R2
    AST_RAM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LM_RAM && wr_en) |=> (store[$past(sel)] == $past(wr_data))); // R3
    AST_RAM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LM_RAM && !wr_en) |=> $stable(store)); // R4
    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LM_SHIFT && wr_en) |=>
        (store == {$past(store[DEPTH-2:0]), $past(shift_in)})); // R5
    AST_SHIFT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LM_SHIFT && !wr_en) |=> $stable(store)); // R7
    AST_REG_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && $past(rst_n)) |-> (lut_out == $past(tap))); // R8
endmodule

bind lut_slice_cell lut_slice_chk #(.SEL_W(SEL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .reg_sel(reg_sel), .sel(sel),
    .wr_data(wr_data), .wr_en(wr_en), .shift_in(shift_in),
    .lut_out(lut_out), .store(mem_bits), .tap(tap_bit)
);

// File: tb/sim_lut_slice_cell.sv
`timescale 1ns/1ps
// Bench for the slice cell: directed corner cases plus seeded random steps,
// compared against a reference model kept in the bench.
module sim_lut_slice_cell;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       reg_sel = 1'b0;
    logic [3:0] sel = 4'd0;
    logic       wr_data = 1'b0, wr_en = 1'b0, shift_in = 1'b0;
    logic       lut_out, shift_out;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;
    logic [15:0] m_bits = '0;
    logic        m_ff = 1'b0;

    always #4 clk = ~clk;

    lut_slice_cell u0 (
        .clk(clk), .rst_n(rst_n), .mode(mode), .reg_sel(reg_sel), .sel(sel),
        .wr_data(wr_data), .wr_en(wr_en), .shift_in(shift_in),
        .lut_out(lut_out), .shift_out(shift_out)
    );

    // Expected output from the reference state.
    function automatic logic exp_out(input logic rs, input logic [3:0] s);
        return rs ? m_ff : m_bits[s];
    endfunction

    // Next reference storage after one edge.
    function automatic logic [15:0] exp_next(input logic [1:0] md, input logic [3:0] s,
                                             input logic wd, input logic we, input logic si);
        logic [15:0] n = m_bits;
        if (we && md == 2'b01) n[s] = wd;
        if (we && md == 2'b10) n = {m_bits[14:0], si};
        return n;
    endfunction

    task automatic check(input string tag, input logic act, input logic expv);
        vectors++;
        if (act !== expv) begin
            miscompares++;
            $display("FAIL %s: got %b expected %b (mode=%b sel=%0d)", tag, act, expv, mode, sel);
        end
    endtask

    // One clocked step: drive, compare before the edge, advance the model.
    task automatic step(input logic [1:0] md, input logic [3:0] s, input logic wd,
                        input logic we, input logic si, input logic rs, input string tag);
        @(negedge clk);
        mode = md; sel = s; wr_data = wd; wr_en = we; shift_in = si; reg_sel = rs;
        #1;
        check(rs ? "R8" : tag, lut_out, exp_out(rs, s));
        check("R5 shift_out", shift_out, m_bits[15]);
        m_ff = m_bits[s];
        m_bits = exp_next(md, s, wd, we, si);
    endtask

    // Read every bit back in logic mode with random disturbances on the data pins.
    task automatic readback(input string tag);
        for (int i = 0; i < 16; i++)
            step(2'b00, 4'(i), 1'($urandom), 1'($urandom), 1'($urandom), 1'b0, tag);
    endtask

    initial begin
        #1600000;
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        // R1: reset clears everything.
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 lut_out", lut_out, 1'b0);
        check("R1 shift_out", shift_out, 1'b0);
        readback("R1");

        // R3: load a truth table z = a & ~b & (c | d) through memory writes.
        for (int i = 0; i < 16; i++) begin
            logic [3:0] v = 4'(i);
            step(2'b01, v, v[3] & ~v[2] & (v[1] | v[0]), 1'b1, 1'b0, 1'b0, "R3");
        end
        // R2 / R9: logic-mode evaluation of the loaded function.
        readback("R2");
        step(2'b11, 4'd9, 1'b1, 1'b1, 1'b1, 1'b0, "R9");
        readback("R9");

        // R4: memory mode, write enable low.
        for (int i = 0; i < 16; i++) step(2'b01, 4'(i), 1'b1, 1'b0, 1'b1, 1'b0, "R4");
        readback("R4");

        // R6: single one marches through the taps.
        for (int i = 0; i < 16; i++) step(2'b10, 4'(15 - i), 1'b0, 1'b1, i == 0, 1'b0, "R6");
        step(2'b10, 4'd15, 1'b0, 1'b1, 1'b0, 1'b0, "R6");
        // R7: shift disabled holds.
        for (int i = 0; i < 8; i++) step(2'b10, 4'(i), 1'b1, 1'b0, 1'b1, 1'b0, "R7");
        readback("R7");

        // R8: registered output during writes reads the old value.
        step(2'b01, 4'd3, 1'b1, 1'b1, 1'b0, 1'b1, "R8");
        step(2'b01, 4'd3, 1'b0, 1'b1, 1'b0, 1'b1, "R8");
        step(2'b01, 4'd3, 1'b0, 1'b0, 1'b0, 1'b1, "R8");

        // Random mixed traffic, mode mostly changing, R9 contents tracked.
        for (int n = 0; n < 3000; n++) begin
            logic [1:0] md = 2'($urandom);
            step(md, 4'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                 ($urandom % 4) == 0, md == 2'b10 ? "R6" : (md == 2'b01 ? "R3" : "R2"));
        end
        readback("R9");

        // R1 again: mid-run reset.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        m_bits = '0; m_ff = 1'b0;
        readback("R1");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule